// File: doc/BRIEF.md
# Programmable Raster Sync and Blanking Generator

This block produces the line and frame timing of a raster display from a small bank of 8-bit timing registers. Software selects a register by writing its index through an index port, then writes the value through a data port. The horizontal counter advances once per character clock, where one character is 8 pixels. The vertical counter advances per scanline, or more slowly when line doubling or the divide-by-two mode is on. Many fields are stored in biased or truncated form. Vertical values have their ninth and tenth bits spread across an overflow register and a scan-control register. The block rebuilds each field and matches it against the running counters.

Each output (horizontal and vertical sync, horizontal and vertical blank, display enable) is a registered flag. The flag updates on the clock after the counter reaches the value that sets or clears it. The block also gives a 16-bit linear character address for the current display row. That address starts each frame from a start address, which is double-buffered at the start of vertical retrace, and then steps by a programmable row pitch.

Bus encoding: `bus_addr` 0 writes the register index (low 5 bits of `bus_wdata`), 1 writes the selected register, 2 writes the sync polarity register, and 3 does nothing. Writes to indices without a defined register are dropped.

Top module: `crt_timing_gen`

## Requirements
- R1: A line lasts (value at index 0x00) + 5 character clocks. The horizontal count runs from 0 up to that total minus 1, and horizontal sync becomes active once per line.
- R2: `disp_en` is high while the horizontal count is at most the value at index 0x01 and the vertical count is at most the 10-bit display end. Its low byte is at index 0x12, bit 8 is index 0x07 bit 1, and bit 9 is index 0x07 bit 6. Over one frame this gives (h+1)*(v+1)*k high clocks, where k is the number of lines per vertical count.
- R3: The horizontal sync flag is set when the horizontal count equals index 0x04. It is cleared when the low 5 bits of the count equal index 0x05 bits 4:0. It is therefore active for (end - start) mod 32 clocks per line.
- R4: `hblank` is set when the horizontal count equals index 0x02. It is cleared when the low 6 bits of the count equal the 6-bit end value, whose bits 4:0 are index 0x03 bits 4:0 and whose bit 5 is index 0x05 bit 7. It lasts (end - start) mod 64 clocks per line.
- R5: A frame lasts (10-bit vertical total) + 2 vertical counts. The low byte is at index 0x06, bit 8 is index 0x07 bit 0, and bit 9 is index 0x07 bit 5.
- R6: The vertical sync flag is set when the vertical count equals the 10-bit sync start. Its low byte is at index 0x10, bit 8 is index 0x07 bit 2, and bit 9 is index 0x07 bit 7. The flag is cleared when the low 4 bits of the count equal index 0x11 bits 3:0.
- R7: `vblank` is set when the vertical count equals the 10-bit blank start. Its low byte is at index 0x15, bit 8 is index 0x07 bit 3, and bit 9 is index 0x09 bit 5. It is cleared when the low 8 bits of the count equal index 0x16.
- R8: Index 0x09 bit 7 (line doubling) and index 0x17 bit 2 (half rate) each make the vertical count advance once per two lines. With both set, it advances once per four lines.
- R9: Polarity register bit 6 makes `hsync` active-low and bit 7 makes `vsync` active-low. When a bit is clear, that sync is active-high.
- R10: While index 0x11 bit 7 is set, writes to indices 0x00 to 0x07 are ignored and the running timing keeps its old values. Clearing the bit makes those registers writable again.
- R11: The 16-bit start address is held at indices 0x0C (high byte) and 0x0D (low byte). It is copied into the active start only when vertical sync becomes active, so a frame already running keeps the address it began with.
- R12: `row_addr` loads the active start address when the vertical count wraps to 0. At every other vertical count step it adds twice the value at index 0x13, modulo 2^16.
- R13: While reset is asserted, every output is 0 and all registers are clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register bus write strobe |
| bus_addr | input | 2 | 0 index, 1 data, 2 polarity |
| bus_wdata | input | 8 | Write data |
| hsync | output | 1 | Horizontal sync, polarity per R9 |
| vsync | output | 1 | Vertical sync, polarity per R9 |
| hblank | output | 1 | Horizontal blanking |
| vblank | output | 1 | Vertical blanking |
| disp_en | output | 1 | Active display area |
| row_addr | output | 16 | Character address of the current row |

## Verification
The bench uses vertical totals above 256 and above 512, and blank and sync starts that need bit 8 or bit 9 of their value. A wrong overflow bit position would then give the wrong frame length or pulse widths. Line doubling and half rate are tested both alone and together, which catches a divider that skips a factor. A start address written in the middle of a frame must not show up until the frame after next: a design without the retrace-time copy would show the new address one frame too early. A sum of start and pitch that passes 2^16 checks that the address wraps rather than saturating. A write to the horizontal total while the lock is on must leave the line length unchanged.

// File: rtl/crt_timing_gen.sv
module crt_timing_gen (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [1:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic        hsync,
  output logic        vsync,
  output logic        hblank,
  output logic        vblank,
  output logic        disp_en,
  output logic [15:0] row_addr
);
  localparam int HW = 9;
  localparam int VW = 11;
  localparam int AW = 16;

  logic [4:0]  idx;
  logic [7:0]  r_htot, r_hde, r_hbs, r_hss, r_vtot, r_vde, r_vbs, r_vss, r_vbe, r_pitch, r_sa_hi, r_sa_lo;
  logic [4:0]  r_hbe, r_hse;
  logic        r_hbe5;
  logic [3:0]  r_vse;
  logic        r_lock, r_dbl, r_half, r_hpol, r_vpol;
  logic        ov_vt8, ov_vt9, ov_vd8, ov_vd9, ov_vb8, ov_vb9, ov_vs8, ov_vs9;

  logic wr_idx, wr_dat, wr_pol, blocked;
  assign wr_idx  = bus_we && (bus_addr == 2'd0);
  assign wr_dat  = bus_we && (bus_addr == 2'd1);
  assign wr_pol  = bus_we && (bus_addr == 2'd2);
  assign blocked = r_lock && (idx < 5'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
      r_htot <= '0; r_hde <= '0; r_hbs <= '0; r_hss <= '0;
      r_vtot <= '0; r_vde <= '0; r_vbs <= '0; r_vss <= '0; r_vbe <= '0;
      r_pitch <= '0; r_sa_hi <= '0; r_sa_lo <= '0;
      r_hbe <= '0; r_hse <= '0; r_hbe5 <= 1'b0; r_vse <= '0;
      r_lock <= 1'b0; r_dbl <= 1'b0; r_half <= 1'b0; r_hpol <= 1'b0; r_vpol <= 1'b0;
      ov_vt8 <= 1'b0; ov_vt9 <= 1'b0; ov_vd8 <= 1'b0; ov_vd9 <= 1'b0;
      ov_vb8 <= 1'b0; ov_vb9 <= 1'b0; ov_vs8 <= 1'b0; ov_vs9 <= 1'b0;
    end else begin
      if (wr_idx) idx <= bus_wdata[4:0];
      if (wr_pol) begin
        r_hpol <= bus_wdata[6];
        r_vpol <= bus_wdata[7];
      end
      if (wr_dat && !blocked) begin
        case (idx)
          5'h00: r_htot <= bus_wdata;
          5'h01: r_hde  <= bus_wdata;
          5'h02: r_hbs  <= bus_wdata;
          5'h03: r_hbe  <= bus_wdata[4:0];
          5'h04: r_hss  <= bus_wdata;
          5'h05: begin
            r_hse  <= bus_wdata[4:0];
            r_hbe5 <= bus_wdata[7];
          end
          5'h06: r_vtot <= bus_wdata;
          5'h07: begin
            ov_vt8 <= bus_wdata[0];
            ov_vd8 <= bus_wdata[1];
            ov_vs8 <= bus_wdata[2];
            ov_vb8 <= bus_wdata[3];
            ov_vt9 <= bus_wdata[5];
            ov_vd9 <= bus_wdata[6];
            ov_vs9 <= bus_wdata[7];
          end
          5'h09: begin
            r_dbl  <= bus_wdata[7];
            ov_vb9 <= bus_wdata[5];
          end
          5'h0C: r_sa_hi <= bus_wdata;
          5'h0D: r_sa_lo <= bus_wdata;
          5'h10: r_vss <= bus_wdata;
          5'h11: begin
            r_vse  <= bus_wdata[3:0];
            r_lock <= bus_wdata[7];
          end
          5'h12: r_vde   <= bus_wdata;
          5'h13: r_pitch <= bus_wdata;
          5'h15: r_vbs   <= bus_wdata;
          5'h16: r_vbe   <= bus_wdata;
          5'h17: r_half  <= bus_wdata[2];
          default: ;
        endcase
      end
    end
  end

  logic [HW-1:0] hlast;
  logic [VW-1:0] vlast, vde_full, vbs_full, vss_full;
  logic [5:0]    hbe_full;
  assign hlast    = {1'b0, r_htot} + 9'd4;
  assign vlast    = {1'b0, ov_vt9, ov_vt8, r_vtot} + 11'd1;
  assign vde_full = {1'b0, ov_vd9, ov_vd8, r_vde};
  assign vbs_full = {1'b0, ov_vb9, ov_vb8, r_vbs};
  assign vss_full = {1'b0, ov_vs9, ov_vs8, r_vss};
  assign hbe_full = {r_hbe5, r_hbe};

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic [1:0]    lcnt, lthr;
  logic          h_wrap, v_step, v_wrap;
  assign h_wrap = hcnt >= hlast;
  assign lthr   = {r_dbl & r_half, r_dbl | r_half};
  assign v_step = h_wrap && (lcnt >= lthr);
  assign v_wrap = vcnt >= vlast;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      lcnt <= '0;
      vcnt <= '0;
    end else begin
      hcnt <= h_wrap ? '0 : hcnt + 9'd1;
      if (h_wrap) lcnt <= v_step ? 2'd0 : lcnt + 2'd1;
      if (v_step) vcnt <= v_wrap ? '0 : vcnt + 11'd1;
    end
  end

  logic hs_q, hb_q, vs_q, vb_q, de_q;
  logic hs_set, hs_clr, hb_set, hb_clr, vs_set, vs_clr, vb_set, vb_clr, vs_rise;
  assign hs_set  = hcnt == {1'b0, r_hss};
  assign hs_clr  = hcnt[4:0] == r_hse;
  assign hb_set  = hcnt == {1'b0, r_hbs};
  assign hb_clr  = hcnt[5:0] == hbe_full;
  assign vs_set  = vcnt == vss_full;
  assign vs_clr  = vcnt[3:0] == r_vse;
  assign vb_set  = vcnt == vbs_full;
  assign vb_clr  = vcnt[7:0] == r_vbe;
  assign vs_rise = vs_set && !vs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b0; hb_q <= 1'b0; vs_q <= 1'b0; vb_q <= 1'b0; de_q <= 1'b0;
    end else begin
      hs_q <= hs_set | (hs_q & ~hs_clr);
      hb_q <= hb_set | (hb_q & ~hb_clr);
      vs_q <= vs_set | (vs_q & ~vs_clr);
      vb_q <= vb_set | (vb_q & ~vb_clr);
      de_q <= (hcnt <= {1'b0, r_hde}) && (vcnt <= vde_full);
    end
  end

  logic [AW-1:0] start_live, row;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_live <= '0;
      row        <= '0;
    end else begin
      if (vs_rise) start_live <= {r_sa_hi, r_sa_lo};
      if (v_step)  row <= v_wrap ? start_live : row + {7'd0, r_pitch, 1'b0};
    end
  end

  assign hsync    = hs_q ^ r_hpol;
  assign vsync    = vs_q ^ r_vpol;
  assign hblank   = hb_q;
  assign vblank   = vb_q;
  assign disp_en  = de_q;
  assign row_addr = row;

  assert_hcount_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !h_wrap |=> hcnt == $past(hcnt) + 9'd1);
  assert_vhold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !v_step |=> $stable(vcnt));
  assert_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && r_lock && idx == 5'h00) |=> $stable(r_htot));
  assert_start_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_rise |=> $stable(start_live));
  assert_reload_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (v_step && v_wrap) |=> row == $past(start_live));
endmodule

// File: tb/crt_timing_gen_bench.sv
`timescale 1ns/1ps
module crt_timing_gen_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, bus_we;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic hsync, vsync, hblank, vblank, disp_en;
  logic [15:0] row_addr;

  crt_timing_gen u_crt_timing_gen (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .hsync(hsync), .vsync(vsync), .hblank(hblank), .vblank(vblank),
    .disp_en(disp_en), .row_addr(row_addr));

  typedef struct packed {
    logic [8:0]  ht;  logic [7:0] hd;  logic [7:0] hbs; logic [5:0] hbe;
    logic [7:0]  hss; logic [4:0] hse;
    logic [10:0] vt;  logic [9:0] vd;  logic [9:0] vbs; logic [7:0] vbe;
    logic [9:0]  vss; logic [3:0] vse;
    logic dbl; logic dv; logic hp; logic vp;
    logic [15:0] sa;  logic [7:0] off;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{9'd20, 8'd15, 8'd15, 6'd18, 8'd16, 5'd18, 11'd40,  10'd29,  10'd29,  8'd37, 10'd32,  4'd4,
      1'b0, 1'b0, 1'b0, 1'b0, 16'h1234, 8'd5},
    '{9'd12, 8'd7,  8'd7,  6'd10, 8'd8,  5'd10, 11'd300, 10'd271, 10'd271, 8'd35, 10'd280, 4'd11,
      1'b1, 1'b0, 1'b1, 1'b0, 16'hFFF0, 8'd40},
    '{9'd10, 8'd7,  8'd7,  6'd9,  8'd8,  5'd9,  11'd530, 10'd511, 10'd515, 8'd9,  10'd520, 4'd11,
      1'b0, 1'b1, 1'b0, 1'b1, 16'h0100, 8'd3},
    '{9'd16, 8'd11, 8'd11, 6'd14, 8'd12, 5'd14, 11'd100, 10'd79,  10'd79,  8'd90, 10'd85,  4'd7,
      1'b1, 1'b1, 1'b1, 1'b1, 16'h8000, 8'd255}
  };

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int c_clk, c_hs, c_hst, c_hb, c_de, c_vs, c_vb;
  logic [15:0] row_at_rise;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic prog(input logic [4:0] i, input logic [7:0] d);
    wr(2'd0, {3'd0, i});
    wr(2'd1, d);
  endtask

  task automatic load(input vec_t v);
    logic [10:0] t;
    t = v.vt - 11'd2;
    prog(5'h11, {4'd0, v.vse});
    prog(5'h00, 8'(v.ht - 9'd5));
    prog(5'h01, v.hd);
    prog(5'h02, v.hbs);
    prog(5'h03, {3'd0, v.hbe[4:0]});
    prog(5'h04, v.hss);
    prog(5'h05, {v.hbe[5], 2'd0, v.hse});
    prog(5'h06, t[7:0]);
    prog(5'h07, {v.vss[9], v.vd[9], t[9], 1'b0, v.vbs[8], v.vss[8], v.vd[8], t[8]});
    prog(5'h09, {v.dbl, 1'b0, v.vbs[9], 5'd0});
    prog(5'h0C, v.sa[15:8]);
    prog(5'h0D, v.sa[7:0]);
    prog(5'h10, v.vss[7:0]);
    prog(5'h12, v.vd[7:0]);
    prog(5'h13, v.off);
    prog(5'h15, v.vbs[7:0]);
    prog(5'h16, v.vbe);
    prog(5'h17, {5'd0, v.dv, 2'd0});
    wr(2'd2, {v.vp, v.hp, 6'd0});
  endtask

  task automatic wait_rise(input logic vp);
    logic prev, cur;
    bit seen;
    seen = 1'b0;
    prev = vsync ^ vp;
    while (!seen) begin
      @(negedge clk);
      cur = vsync ^ vp;
      if (cur && !prev) seen = 1'b1;
      prev = cur;
    end
  endtask

  task automatic measure(input logic hp, input logic vp);
    logic ph, h0, pv, cv, ch;
    bit done;
    wait_rise(vp);
    row_at_rise = row_addr;
    ph = hsync ^ hp;
    h0 = ph;
    c_clk = 1; c_hs = ph ? 1 : 0; c_hst = 0;
    c_hb = hblank ? 1 : 0; c_de = disp_en ? 1 : 0; c_vs = 1; c_vb = vblank ? 1 : 0;
    pv = 1'b1;
    done = 1'b0;
    while (!done) begin
      @(negedge clk);
      cv = vsync ^ vp;
      if (cv && !pv) done = 1'b1;
      else begin
        ch = hsync ^ hp;
        c_clk++;
        if (ch) c_hs++;
        if (ch && !ph) c_hst++;
        ph = ch;
        if (hblank) c_hb++;
        if (disp_en) c_de++;
        if (cv) c_vs++;
        if (vblank) c_vb++;
      end
      pv = cv;
    end
    if (h0 && !ph) c_hst++;
  endtask

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = 2'd0; bus_wdata = 8'd0;
    repeat (5) @(negedge clk);
    // R13 reset state
    chk("R13", "hsync in reset", hsync, 0);
    chk("R13", "vsync in reset", vsync, 0);
    chk("R13", "hblank in reset", hblank, 0);
    chk("R13", "vblank in reset", vblank, 0);
    chk("R13", "disp_en in reset", disp_en, 0);
    chk("R13", "row_addr in reset", row_addr, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 4; i++) begin
      vec_t v;
      int step, lines, hsw, hbw, vsw, vbw;
      v = VECS[i];
      load(v);
      wait_rise(v.vp);
      measure(v.hp, v.vp);
      step  = (v.dbl ? 2 : 1) * (v.dv ? 2 : 1);
      lines = int'(v.vt) * step;
      hsw = (int'(v.hse) - int'(v.hss[4:0])) & 31;
      hbw = (int'(v.hbe) - int'(v.hbs[5:0])) & 63;
      vsw = (int'(v.vse) - int'(v.vss[3:0])) & 15;
      vbw = (int'(v.vbe) - int'(v.vbs[7:0])) & 255;
      chk("R1", "hsync starts per frame", c_hst, lines);
      chk("R5/R8", "frame length", c_clk, lines * int'(v.ht));
      chk("R2", "display enable clocks", c_de, (int'(v.hd) + 1) * (int'(v.vd) + 1) * step);
      chk("R3/R9", "hsync active clocks", c_hs, lines * hsw);
      chk("R4", "hblank clocks", c_hb, lines * hbw);
      chk("R6/R9", "vsync active clocks", c_vs, vsw * step * int'(v.ht));
      chk("R7", "vblank clocks", c_vb, vbw * step * int'(v.ht));
      chk("R12", "row address at retrace", row_at_rise,
          (int'(v.sa) + int'(v.vss) * int'(v.off) * 2) & 32'hFFFF);
    end

    // R10 write lock on indices 0..7
    load(VECS[0]);
    wait_rise(1'b0);
    prog(5'h11, 8'h84);
    prog(5'h00, 8'd20);
    wait_rise(1'b0);
    measure(1'b0, 1'b0);
    chk("R10", "frame length with lock on", c_clk, 800);
    prog(5'h11, 8'h04);
    prog(5'h00, 8'd20);
    wait_rise(1'b0);
    measure(1'b0, 1'b0);
    chk("R10", "frame length after unlock", c_clk, 1000);
    prog(5'h00, 8'd15);

    // R11 start address takes effect only at retrace
    wait_rise(1'b0);
    wait_rise(1'b0);
    wait_rise(1'b0);
    prog(5'h0C, 8'hAB);
    prog(5'h0D, 8'hCD);
    wait_rise(1'b0);
    chk("R11", "row address keeps old start", row_addr, 16'h1374);
    wait_rise(1'b0);
    chk("R11", "row address uses new start", row_addr, 16'hAD0D);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule